// File: doc/BRIEF.md
# MDIO Management Controller

A bus-slave peripheral that lets a processor read and write the management registers of an Ethernet PHY over the two-wire MDC/MDIO interface. Software programs a PHY address and a register number, then starts a transaction as a side effect of a register write. Writing the 16-bit data register launches a write frame. Setting the read-start bit from 0 to 1 launches a read frame.

The block builds the MDC clock from the system clock with a programmable divider. It shifts out a 64-bit management frame, MSB first: 32 preamble ones, start code `01`, opcode (`01` write, `10` read), 5-bit PHY address, 5-bit register number, a 2-bit turnaround and 16 data bits. During a read it releases MDIO for the turnaround and data bits, and it samples the returned bits on rising MDC edges. The indication register shows a busy flag and a separate read-pending flag. Software polls these flags and then collects the data from the status register.

A soft-reset bit in the configuration register aborts any frame in flight.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset:
  - the indication, address, control, status and read-start registers read 0;
  - the configuration register reads 7;
  - `mdc` is low and `mdio_oe` is low.
- R2: Register map (byte offsets, bits 4:2 of `bus_addr` select the register):
  - 0x00 configuration: divider N in bits 2:0; soft reset in bit 31, which always reads 0.
  - 0x04 read-start: bit 0.
  - 0x08 target: PHY address in bits 12:8 and register number in bits 4:0; all other bits read 0.
  - 0x0C write data: bits 15:0.
  - 0x10 status: read-only, read data in bits 15:0.
  - 0x14 indication: read-only, busy in bit 0 and read-pending in bit 2.
  - Register reads have no side effects. Writes to status and indication change nothing.
- R3: A write to the write-data register while idle sends the frame: 32 ones, `01`, `01`, PHY address, register number, `10`, then the 16 data bits, MSB first. This is exactly 64 MDC rising edges.
- R4: A read frame sends 32 ones, `01`, `10`, PHY address and register number. `mdio_oe` is low for the last 18 bit times. The 16 bits sampled on the last 16 MDC rising edges appear, MSB first, in status bits 15:0.
- R5: While a frame runs, the MDC period is 8×(N+1) system clocks. `mdio_o` changes only while MDC is low.
- R6: Busy reads 1 from the cycle after a start until the MDC falling edge that ends bit 63. While idle, MDC is held low and MDIO is released.
- R7: Read-pending is set when a read starts. It clears when the last data bit is captured, while busy is still 1.
- R8: A start request while busy is ignored. A write-data write is dropped and the register keeps its old value. A read-start write stores the bit but starts no frame.
- R9: Writing 1 to configuration bit 31 aborts any frame:
  - busy, read-pending and the read-start bit clear in the next cycle;
  - MDC returns low and MDIO is released;
  - the divider takes bits 2:0 of the same write.
- R10: Writing 1 to the read-start bit while it already holds 1 starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench sends write frames at all eight divider settings, each with different PHY, register and data fields. These sweeps tell a wrong MDC period apart from a wrong bit order or a wrong field placement. Read frames run across corner addresses (all zeros, all ones, mixed) against a PHY model whose reply is a function of the address. This separates header errors from capture errors and from turnaround-release errors. Start requests while busy, a repeated read-start, and a soft reset part-way through a read check that a frame never restarts or gets cut short, and that an abort leaves the bus quiet.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and request type for the MDIO management controller.
// Assumes Clause-22 framing only; frame layout constants live here so the
// register file and the frame engine agree on them.
package mdio_mgmt_pkg;
    localparam int DATA_W  = 16;
    localparam int PHYAD_W = 5;
    localparam int REGAD_W = 5;
    localparam int PRE_LEN = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHYAD_W + REGAD_W + 2 + DATA_W;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OPC_WRITE  = 2'b01;
    localparam logic [1:0] OPC_READ   = 2'b10;
    localparam logic [1:0] TURN_WRITE = 2'b10;

    // register select, taken from byte address bits 4:2
    localparam logic [2:0] SEL_CFG = 3'd0;
    localparam logic [2:0] SEL_CMD = 3'd1;
    localparam logic [2:0] SEL_TGT = 3'd2;
    localparam logic [2:0] SEL_WDT = 3'd3;
    localparam logic [2:0] SEL_STS = 3'd4;
    localparam logic [2:0] SEL_IND = 3'd5;

    typedef struct packed {
        logic               is_read;
        logic [PHYAD_W-1:0] phy;
        logic [REGAD_W-1:0] regad;
        logic [DATA_W-1:0]  wdata;
    } mdio_req_t;
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator: while run is high, toggles mdc every (div_sel+1)*PRESCALE
// system clocks and flags the cycle before each rising / falling edge.
// Assumes run drops to stop the clock; mdc is then forced low next cycle.
module mdio_clk_gen #(
    parameter int DIV_W    = 3,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int CNT_W = DIV_W + $clog2(PRESCALE) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             mdc_q;
    logic             wrap;

    // last count of one half period
    assign half_m1 = (CNT_W'(div_sel) + CNT_W'(1)) * CNT_W'(PRESCALE) - CNT_W'(1);
    assign wrap    = run && (cnt_q >= half_m1);

    // half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = wrap && !mdc_q;
    assign fall_stb = wrap && mdc_q;

    // R6
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc_q);
endmodule

// File: rtl/mdio_frame_eng.sv
// Frame engine: loads a 64-bit management frame on start, shifts one bit
// per MDC falling edge, releases MDIO for read turnaround/data and captures
// read bits on MDC rising edges. Assumes strobes come from mdio_clk_gen.
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              abort,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              rd_pending,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(FRAME_LEN - DATA_W - 2);
    localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(FRAME_LEN - DATA_W);

    logic [FRAME_LEN-1:0] shreg_q;
    logic [CNT_W-1:0]     bitcnt_q;
    logic                 busy_q;
    logic                 is_rd_q;
    logic                 pend_q;
    logic [DATA_W-2:0]    cap_q;
    logic [DATA_W-1:0]    rdat_q;
    logic                 launch;
    logic [1:0]           opc;
    logic [1:0]           turn;
    logic [DATA_W-1:0]    dfield;

    assign launch = start && !busy_q;
    assign opc    = req.is_read ? OPC_READ : OPC_WRITE;
    assign turn   = req.is_read ? 2'b11 : TURN_WRITE;
    assign dfield = req.is_read ? '1 : req.wdata;

    // frame sequencing: load, shift on falling MDC, finish after last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            is_rd_q  <= 1'b0;
            bitcnt_q <= '0;
            shreg_q  <= '1;
        end else if (abort) begin
            busy_q   <= 1'b0;
        end else if (launch) begin
            busy_q   <= 1'b1;
            is_rd_q  <= req.is_read;
            bitcnt_q <= '0;
            shreg_q  <= {{PRE_LEN{1'b1}}, START_CODE, opc, req.phy, req.regad, turn, dfield};
        end else if (busy_q && fall_stb) begin
            if (bitcnt_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                bitcnt_q <= bitcnt_q + CNT_W'(1);
                shreg_q  <= {shreg_q[FRAME_LEN-2:0], 1'b1};
            end
        end
    end

    // read capture and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cap_q  <= '0;
            rdat_q <= '0;
        end else if (abort) begin
            pend_q <= 1'b0;
        end else if (launch && req.is_read) begin
            pend_q <= 1'b1;
        end else if (busy_q && is_rd_q && rise_stb && bitcnt_q >= DATA_IDX) begin
            cap_q <= {cap_q[DATA_W-3:0], mdio_i};
            if (bitcnt_q == LAST_IDX) begin
                rdat_q <= {cap_q, mdio_i};
                pend_q <= 1'b0;
            end
        end
    end

    assign busy       = busy_q;
    assign rd_pending = pend_q;
    assign rd_data    = rdat_q;
    assign mdio_o     = shreg_q[FRAME_LEN-1];
    assign mdio_oe    = busy_q && !(is_rd_q && bitcnt_q >= TA_IDX);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !fall_stb && !abort |=> busy_q && $stable(bitcnt_q) && $stable(is_rd_q));
    // R7
    pend_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_q);
    // R6
    full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) && !$past(abort) |-> $past(bitcnt_q) == LAST_IDX && $past(fall_stb));
endmodule

// File: rtl/mdio_regs.sv
// Register file: decodes the six word registers, holds divider, read-start
// bit, target address and write data, and turns writes into frame starts or
// a soft reset. Assumes word-aligned accesses; reads are side-effect free.
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          DIV_W    = 3,
    parameter int unsigned DIV_INIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              rd_pending,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_sel,
    output logic              start,
    output mdio_req_t         req,
    output logic              soft_rst
);
    logic [2:0]         sel;
    logic               wr_cfg, wr_cmd, wr_tgt, wr_wdt;
    logic               start_wr, start_rd;
    logic [DIV_W-1:0]   div_q;
    logic               cmd_q;
    logic [PHYAD_W-1:0] phy_q;
    logic [REGAD_W-1:0] regad_q;
    logic [DATA_W-1:0]  wdt_q;
    logic               unused_bits;

    assign sel    = bus_addr[4:2];
    assign wr_cfg = bus_wr && sel == SEL_CFG;
    assign wr_cmd = bus_wr && sel == SEL_CMD;
    assign wr_tgt = bus_wr && sel == SEL_TGT;
    assign wr_wdt = bus_wr && sel == SEL_WDT;

    assign soft_rst = wr_cfg && bus_wdata[31];
    assign start_wr = wr_wdt && !busy;
    assign start_rd = wr_cmd && bus_wdata[0] && !cmd_q && !busy;
    assign start    = start_wr || start_rd;

    assign req.is_read = start_rd;
    assign req.phy     = phy_q;
    assign req.regad   = regad_q;
    assign req.wdata   = bus_wdata[DATA_W-1:0];
    assign div_sel     = div_q;

    // configuration and read-start bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_INIT);
            cmd_q <= 1'b0;
        end else begin
            if (wr_cfg) div_q <= bus_wdata[DIV_W-1:0];
            if (soft_rst)    cmd_q <= 1'b0;
            else if (wr_cmd) cmd_q <= bus_wdata[0];
        end
    end

    // target address and write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q   <= '0;
            regad_q <= '0;
            wdt_q   <= '0;
        end else begin
            if (wr_tgt) begin
                phy_q   <= bus_wdata[8 +: PHYAD_W];
                regad_q <= bus_wdata[0 +: REGAD_W];
            end
            if (start_wr) wdt_q <= bus_wdata[DATA_W-1:0];
        end
    end

    // read-data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CFG: bus_rdata[DIV_W-1:0] = div_q;
            SEL_CMD: bus_rdata[0] = cmd_q;
            SEL_TGT: begin
                bus_rdata[8 +: PHYAD_W] = phy_q;
                bus_rdata[0 +: REGAD_W] = regad_q;
            end
            SEL_WDT: bus_rdata[DATA_W-1:0] = wdt_q;
            SEL_STS: bus_rdata[DATA_W-1:0] = rd_data;
            SEL_IND: begin
                bus_rdata[0] = busy;
                bus_rdata[2] = rd_pending;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:16]};

    // R8
    wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wdt_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top of the MDIO management controller: register file, MDC generator and
// frame engine. Assumes a single bus master and separate MDIO in/out pins
// with an external tri-state buffer driven by mdio_oe.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          DIV_W    = 3,
    parameter int          PRESCALE = 4,
    parameter int unsigned DIV_INIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, rd_pending, start, soft_rst;
    logic              rise_stb, fall_stb;
    logic [DATA_W-1:0] rd_data;
    logic [DIV_W-1:0]  div_sel;
    mdio_req_t         req;

    mdio_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rd_pending(rd_pending), .rd_data(rd_data), .div_sel(div_sel),
        .start(start), .req(req), .soft_rst(soft_rst)
    );

    mdio_clk_gen #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .div_sel(div_sel),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .abort(soft_rst),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(busy), .rd_pending(rd_pending), .rd_data(rd_data),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy && !rd_pending);
    // R5
    mdc_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc && $past(mdc) |-> $stable(mdio_o));
    // R6
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
    localparam logic [4:0] A_CFG = 5'h00, A_CMD = 5'h04, A_TGT = 5'h08,
                           A_WDT = 5'h0C, A_STS = 5'h10, A_IND = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drv = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // PHY model state
    int          rcnt = 0;
    int          base = 0;
    logic [63:0] rx = '0;
    logic [63:0] oeh = '0;
    logic [15:0] resp = '0;
    longint      cyc = 0;
    longint      last_rise = 0;
    longint      period = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drv)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: sample on MDC rise
    always @(posedge mdc) begin
        rx = {rx[62:0], mdio_oe ? mdio_o : 1'b1};
        oeh = {oeh[62:0], mdio_oe};
        rcnt = rcnt + 1;
        period = cyc - last_rise;
        last_rise = cyc;
    end

    // PHY model: drive read data after MDC fall
    always @(negedge mdc) begin
        if ((rcnt - base) >= 48 && (rcnt - base) <= 63)
            phy_drv <= resp[63 - (rcnt - base)];
        else if ((rcnt - base) == 47)
            phy_drv <= 1'b0;
        else
            phy_drv <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_IND, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    function automatic logic [15:0] phy_reply(input logic [4:0] p, input logic [4:0] r);
        return (16'({p, r}) * 16'd1237) ^ 16'h5A3C;
    endfunction

    task automatic run_write(input int n, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        logic [63:0] exp_f;
        wr(A_CFG, 32'(n));
        wr(A_TGT, {19'd0, p, 3'd0, r});
        base = rcnt;
        wr(A_WDT, {16'd0, d});
        wait_idle();
        exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
        chk(rcnt - base == 64, "R3 edge count", 64'(rcnt - base), 64);
        chk(rx == exp_f, "R3 write frame", rx, exp_f);
        chk(period == 64'(8 * (n + 1)), "R5 mdc period", 64'(period), 64'(8 * (n + 1)));
    endtask

    task automatic run_read(input int n, input logic [4:0] p, input logic [4:0] r);
        logic [31:0] v;
        logic [45:0] exp_h;
        bit seen_busy;
        wr(A_CFG, 32'(n));
        wr(A_TGT, {19'd0, p, 3'd0, r});
        resp = phy_reply(p, r);
        wr(A_CMD, 32'd0);
        base = rcnt;
        wr(A_CMD, 32'd1);
        rd(A_IND, v);
        chk(v == 32'h5, "R6 R7 flags at read start", 64'(v), 64'h5);
        seen_busy = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            rd(A_IND, v);
            if (v[2] == 1'b0) begin
                seen_busy = v[0];
                break;
            end
        end
        chk(seen_busy, "R7 pending clears before busy", 64'(seen_busy), 1);
        wait_idle();
        exp_h = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
        chk(rx[63:18] == exp_h, "R4 read header", 64'(rx[63:18]), 64'(exp_h));
        chk(oeh[17:0] == 18'd0 && oeh[63:18] == '1, "R4 turnaround release", oeh, {46'h3FFF_FFFF_FFFF, 18'd0});
        rd(A_STS, v);
        chk(v == {16'd0, resp}, "R4 read data", 64'(v), 64'(resp));
    endtask

    initial begin
        #1_200_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] snap;
        int rsnap;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_IND, v); chk(v == 0, "R1 indication", 64'(v), 0);
        rd(A_CFG, v); chk(v == 7, "R1 configuration", 64'(v), 7);
        rd(A_TGT, v); chk(v == 0, "R1 target", 64'(v), 0);
        rd(A_WDT, v); chk(v == 0, "R1 write data", 64'(v), 0);
        rd(A_STS, v); chk(v == 0, "R1 status", 64'(v), 0);
        rd(A_CMD, v); chk(v == 0, "R1 read-start", 64'(v), 0);
        chk(!mdc && !mdio_oe, "R1 pins idle", {mdc, mdio_oe}, 0);

        // R2 register map
        wr(A_TGT, 32'hFFFF_FFFF);
        rd(A_TGT, v); chk(v == 32'h1F1F, "R2 target mask", 64'(v), 64'h1F1F);
        wr(A_TGT, 32'h0);
        wr(A_STS, 32'h1234);
        rd(A_STS, v); chk(v == 0, "R2 status read-only", 64'(v), 0);
        wr(A_IND, 32'hFFFF_FFFF);
        rd(A_IND, v); chk(v == 0, "R2 indication read-only", 64'(v), 0);
        rd(A_IND, v); chk(v == 0, "R2 read has no side effect", 64'(v), 0);

        // R3 R5 write sweep over all divider settings
        for (int n = 0; n < 8; n++)
            run_write(n, 5'((n * 3 + 1) % 32), 5'(31 - n * 4), 16'h8001 ^ 16'(n * 16'h1111));
        rd(A_WDT, v); chk(v == 32'(16'h8001 ^ 16'(7 * 16'h1111)), "R2 write data readback", 64'(v), 64'(16'h8001 ^ 16'(7 * 16'h1111)));

        // R4 read sweep over corner addresses
        run_read(0, 5'd0, 5'd0);
        run_read(0, 5'd31, 5'd31);
        run_read(0, 5'd21, 5'd10);
        run_read(0, 5'd1, 5'd30);
        run_read(2, 5'd12, 5'd3);

        // R8 starts while busy are ignored
        wr(A_CFG, 32'd0);
        wr(A_TGT, {19'd0, 5'd4, 3'd0, 5'd9});
        wr(A_CMD, 32'd0);
        base = rcnt;
        wr(A_WDT, 32'h0000_C3A5);
        repeat (20) @(negedge clk);
        wr(A_WDT, 32'h0000_1111);
        rd(A_WDT, v); chk(v == 32'hC3A5, "R8 write data dropped", 64'(v), 64'hC3A5);
        wr(A_CMD, 32'd1);
        wait_idle();
        chk(rx == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd9, 2'b10, 16'hC3A5}, "R8 frame intact", rx,
            {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd4, 5'd9, 2'b10, 16'hC3A5});
        rsnap = rcnt;
        repeat (100) @(negedge clk);
        rd(A_IND, v); chk(v == 0, "R8 no read started", 64'(v), 0);
        chk(rcnt == rsnap, "R8 no extra edges", 64'(rcnt), 64'(rsnap));
        rd(A_CMD, v); chk(v == 1, "R8 read-start stored", 64'(v), 1);

        // R10 level 1 without a 0->1 change starts nothing
        wr(A_CMD, 32'd1);
        rd(A_IND, v); chk(v == 0, "R10 no start on held bit", 64'(v), 0);

        // R9 soft reset mid-read
        wr(A_CFG, 32'd3);
        wr(A_CMD, 32'd0);
        base = rcnt;
        wr(A_CMD, 32'd1);
        repeat (200) @(negedge clk);
        wr(A_CFG, 32'h8000_0005);
        rd(A_IND, v); chk(v == 0, "R9 flags cleared", 64'(v), 0);
        repeat (2) @(negedge clk);
        chk(!mdc && !mdio_oe, "R9 pins quiet", {mdc, mdio_oe}, 0);
        rd(A_CFG, v); chk(v == 5, "R9 divider taken, bit31 reads 0", 64'(v), 5);
        rd(A_CMD, v); chk(v == 0, "R9 read-start cleared", 64'(v), 0);
        snap = 64'(rcnt);
        repeat (100) @(negedge clk);
        chk(64'(rcnt) == snap, "R9 mdc stopped", 64'(rcnt), snap);
        run_read(0, 5'd7, 5'd17);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule